// File: doc/BRIEF.md
# Windowed Address Translation Unit

This block turns a 32-bit virtual address into a physical address. It uses a small set of programmable windows, each covering 16 MiB or more. A window is picked by a masked compare of the top address byte. The lower 24 address bits pass through unchanged. The window that matches supplies the physical top byte, a memory attribute and the protection rules for the access.

A request gives the address, a write flag and a user flag. One cycle later the block returns one of these outcomes:
- a translated address with its attribute (hit);
- a miss, so that a later stage can take over;
- a protection fault with a coded cause.

On a fault the block keeps the faulting address and the cause in two registers. A word-wide register port reads and writes these two registers, the control register and the window registers.

While translation is off, addresses pass straight through and no rights are checked.

Top module: `win_xlate`

## Requirements
- R1: After reset the control, fault address and fault cause registers read 0. Window 0 reads 0x0000F005, window 1 reads 0xFDF0FF0D and window 2 reads 0xFEF0FF1D. The register addresses are:
  - control: 0
  - fault address: 1
  - fault cause: 2
  - window n: 4+n
- R2: While control bit 0 is 0:
  - a request returns the physical address equal to the virtual address;
  - the attribute is 00;
  - hit, miss and fault are all 0;
  - the fault registers are unchanged for every kind of access.
- R3: Each request raises `rsp_valid` and the response outputs exactly one clock edge after `req_valid` is sampled. `rsp_hit`, `rsp_miss` and `rsp_fault` are 0 in any cycle without a response.
- R4: A window register holds the virtual byte in bits 31:24, the physical byte in 23:16 and the mask in 15:8. A window matches when the virtual address bits 31:24 equal its virtual byte at every position where the mask is 1. Physical bits 23:0 always equal virtual bits 23:0.
- R5: On a match, physical bits 31:24 are formed bit by bit: where the mask is 1 the bit comes from the window's physical byte, and where it is 0 the bit comes from the virtual address.
- R6: On a hit, `rsp_attr` equals window bits 4:3, coded as follows:
  - 00: uncached
  - 01: cacheable
  - 10: byte-writeable shared
  - 11: shared
- R7: When several windows match, the lowest-numbered one alone decides the result, including its faults.
- R8: When translation is on and no window matches, `rsp_miss` is 1 and the physical address equals the virtual address.
- R9: On a match, the 4-bit cause is built from the matched window's protection bits (valid bit 0, read-only bit 1, supervisor-only bit 2):
  - cause bit 0 is set if the window's valid bit is 0;
  - cause bit 1 is set on a write to a window with the read-only bit set;
  - cause bit 2 is set on a user access to a window with the supervisor-only bit set;
  - cause bit 3 is always 0.

  A nonzero cause gives `rsp_fault` 1 and `rsp_hit` 0, and the cause appears on `rsp_cause`.
- R10: A fault loads the virtual address into the fault address register and the cause into the fault cause register. Both keep their value through later requests until software writes them.
- R11: Control bit 0 enables translation. Control bit 1 reads 1 if the last lookup made with translation on matched a window, and 0 otherwise. Software writes to bit 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = user access, 0 = supervisor |
| rsp_valid | output | 1 | Response present |
| rsp_pa | output | 32 | Physical address |
| rsp_attr | output | 2 | Memory attribute |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No window matched |
| rsp_fault | output | 1 | Protection fault |
| rsp_cause | output | 4 | Fault cause code |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |

## Verification
The hardest case to reach is a request that matches two windows at once. Only there can the priority rule be told apart, and at reset the windows never overlap. The bench rewrites window 1 so that it also covers the low region handled by window 0. It then marks window 0 invalid, so the lower window wins even though it faults. A partial mask then shows that virtual bits fill in wherever the mask is 0.

// File: rtl/win_xlate_pkg.sv
package win_xlate_pkg;

   localparam int VA_W   = 32;
   localparam int TAG_W  = 8;
   localparam int TAG_LSB = VA_W - TAG_W;
   localparam int CAUSE_W = 4;

   localparam int REG_CTRL   = 0;
   localparam int REG_FVA    = 1;
   localparam int REG_FCAUSE = 2;

   typedef enum logic [1:0] {
      ATTR_UNCACHED    = 2'b00,
      ATTR_CACHED      = 2'b01,
      ATTR_BYTE_SHARED = 2'b10,
      ATTR_SHARED      = 2'b11
   } attr_e;

   typedef struct packed {
      logic [TAG_W-1:0] vtag;
      logic [TAG_W-1:0] ptag;
      logic [TAG_W-1:0] mask;
      logic [2:0]       spare;
      attr_e            attr;
      logic             sup_only;
      logic             rd_only;
      logic             valid;
   } win_t;

   function automatic logic [VA_W-1:0] win_default(input int unsigned idx);
      case (idx)
         0:       return 32'h0000_F005;
         1:       return 32'hFDF0_FF0D;
         2:       return 32'hFEF0_FF1D;
         default: return '0;
      endcase
   endfunction

endpackage

// File: rtl/win_match.sv
module win_match
   import win_xlate_pkg::*;
#(
   parameter int NWIN = 3
) (
   input  win_t [NWIN-1:0]   win,
   input  logic [TAG_W-1:0]  vtag,
   output logic [NWIN-1:0]   hit
);
   for (genvar g = 0; g < NWIN; g++) begin : g_cmp
      assign hit[g] = ((vtag ^ win[g].vtag) & win[g].mask) == '0;
   end
endmodule

// File: rtl/win_resolve.sv
module win_resolve
   import win_xlate_pkg::*;
#(
   parameter int NWIN = 3
) (
   input  win_t [NWIN-1:0]    win,
   input  logic [NWIN-1:0]    hit,
   input  logic [VA_W-1:0]    va,
   input  logic               is_write,
   input  logic               is_user,
   output logic               any_hit,
   output logic [VA_W-1:0]    pa,
   output attr_e              attr,
   output logic [CAUSE_W-1:0] cause
);
   win_t sel;

   always_comb begin
      sel = '0;
      for (int i = NWIN - 1; i >= 0; i--) begin
         if (hit[i]) sel = win[i];
      end
   end

   assign any_hit = |hit;

   always_comb begin
      pa = va;
      if (any_hit) begin
         pa[VA_W-1:TAG_LSB] = (sel.ptag & sel.mask) | (va[VA_W-1:TAG_LSB] & ~sel.mask);
      end
      attr  = any_hit ? sel.attr : ATTR_UNCACHED;
      cause = '0;
      if (any_hit) begin
         cause[0] = ~sel.valid;
         cause[1] = is_write & sel.rd_only;
         cause[2] = is_user & sel.sup_only;
      end
   end
endmodule

// File: rtl/win_csr.sv
module win_csr
   import win_xlate_pkg::*;
#(
   parameter int NWIN = 3,
   parameter int RA_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [RA_W-1:0]    reg_addr,
   input  logic [VA_W-1:0]    reg_wdata,
   output logic [VA_W-1:0]    reg_rdata,
   input  logic               match_upd,
   input  logic               match_val,
   input  logic               fault_set,
   input  logic [VA_W-1:0]    fault_va,
   input  logic [CAUSE_W-1:0] fault_cause,
   output logic               xlate_en,
   output win_t [NWIN-1:0]    win,
   output logic [VA_W-1:0]    fva_q,
   output logic [CAUSE_W-1:0] fcause_q
);
   localparam int WIN_BASE = 1 << (RA_W - 1);

   logic match_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xlate_en <= 1'b0;
         match_q  <= 1'b0;
      end else begin
         if (reg_we && reg_addr == RA_W'(REG_CTRL)) xlate_en <= reg_wdata[0];
         if (match_upd) match_q <= match_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fva_q    <= '0;
         fcause_q <= '0;
      end else if (fault_set) begin
         fva_q    <= fault_va;
         fcause_q <= fault_cause;
      end else if (reg_we) begin
         if (reg_addr == RA_W'(REG_FVA))    fva_q    <= reg_wdata;
         if (reg_addr == RA_W'(REG_FCAUSE)) fcause_q <= reg_wdata[CAUSE_W-1:0];
      end
   end

   for (genvar g = 0; g < NWIN; g++) begin : g_win
      localparam logic [RA_W-1:0] MY_ADDR = RA_W'(WIN_BASE + g);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          win[g] <= win_t'(win_default(g));
         else if (reg_we && reg_addr == MY_ADDR) win[g] <= win_t'(reg_wdata);
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == RA_W'(REG_CTRL))   reg_rdata = {{(VA_W-2){1'b0}}, match_q, xlate_en};
      if (reg_addr == RA_W'(REG_FVA))    reg_rdata = fva_q;
      if (reg_addr == RA_W'(REG_FCAUSE)) reg_rdata = {{(VA_W-CAUSE_W){1'b0}}, fcause_q};
      for (int i = 0; i < NWIN; i++) begin
         if (reg_addr == RA_W'(WIN_BASE + i)) reg_rdata = win[i];
      end
   end
endmodule

// File: rtl/win_xlate.sv
module win_xlate
   import win_xlate_pkg::*;
#(
   parameter int NWIN = 3,
   parameter int RA_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [31:0]        req_va,
   input  logic               req_write,
   input  logic               req_user,
   output logic               rsp_valid,
   output logic [31:0]        rsp_pa,
   output logic [1:0]         rsp_attr,
   output logic               rsp_hit,
   output logic               rsp_miss,
   output logic               rsp_fault,
   output logic [3:0]         rsp_cause,
   input  logic               reg_we,
   input  logic [RA_W-1:0]    reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata
);
   initial begin
      if (NWIN < 1 || NWIN > (1 << (RA_W - 1)))
         $error("win_xlate: NWIN must lie in 1..2**(RA_W-1)");
      if (RA_W < 2)
         $error("win_xlate: RA_W too small for the register map");
   end

   win_t [NWIN-1:0]    win;
   logic [NWIN-1:0]    hit_vec;
   logic               xlate_en;
   logic               any_hit;
   logic [VA_W-1:0]    xl_pa;
   attr_e              xl_attr;
   logic [CAUSE_W-1:0] xl_cause;
   logic [VA_W-1:0]    fva_q;
   logic [CAUSE_W-1:0] fcause_q;
   logic               is_fault;

   win_match #(.NWIN(NWIN)) u_match (
      .win  (win),
      .vtag (req_va[VA_W-1:TAG_LSB]),
      .hit  (hit_vec)
   );

   win_resolve #(.NWIN(NWIN)) u_resolve (
      .win      (win),
      .hit      (hit_vec),
      .va       (req_va),
      .is_write (req_write),
      .is_user  (req_user),
      .any_hit  (any_hit),
      .pa       (xl_pa),
      .attr     (xl_attr),
      .cause    (xl_cause)
   );

   assign is_fault = req_valid && xlate_en && any_hit && (xl_cause != '0);

   win_csr #(.NWIN(NWIN), .RA_W(RA_W)) u_csr (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_we      (reg_we),
      .reg_addr    (reg_addr),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .match_upd   (req_valid && xlate_en),
      .match_val   (any_hit),
      .fault_set   (is_fault),
      .fault_va    (req_va),
      .fault_cause (xl_cause),
      .xlate_en    (xlate_en),
      .win         (win),
      .fva_q       (fva_q),
      .fcause_q    (fcause_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_pa    <= '0;
         rsp_attr  <= '0;
         rsp_hit   <= 1'b0;
         rsp_miss  <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_cause <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_hit   <= 1'b0;
         rsp_miss  <= 1'b0;
         rsp_fault <= 1'b0;
         if (req_valid) begin
            rsp_cause <= '0;
            if (!xlate_en) begin
               rsp_pa   <= req_va;
               rsp_attr <= ATTR_UNCACHED;
            end else begin
               rsp_pa    <= xl_pa;
               rsp_attr  <= xl_attr;
               rsp_miss  <= ~any_hit;
               rsp_hit   <= any_hit && (xl_cause == '0);
               rsp_fault <= is_fault;
               rsp_cause <= xl_cause;
            end
         end
      end
   end
endmodule

// File: rtl/win_xlate_chk.sv
module win_xlate_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic [31:0] req_va,
   input logic        reg_we,
   input logic [2:0]  reg_addr,
   input logic        rsp_valid,
   input logic [31:0] rsp_pa,
   input logic        rsp_hit,
   input logic        rsp_miss,
   input logic        rsp_fault,
   input logic [3:0]  rsp_cause,
   input logic        xlate_en,
   input logic [31:0] fva_q
);
   // R3
   resp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid == $past(req_valid));

   // R3
   flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_hit, rsp_miss, rsp_fault}) && (rsp_hit || rsp_miss || rsp_fault) |-> rsp_valid);

   // R4
   low_bits_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_pa[23:0] == $past(req_va[23:0]));

   // R2
   bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !$past(xlate_en) |-> rsp_pa == $past(req_va) && !rsp_fault && !rsp_hit && !rsp_miss);

   // R9
   fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> rsp_cause != 4'h0 && rsp_cause[3] == 1'b0);

   // R10
   fault_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> fva_q == $past(req_va));

   // R10
   fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_fault && !$past(reg_we && reg_addr == 3'd1) |-> $stable(fva_q));
endmodule

bind win_xlate win_xlate_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_va    (req_va),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .rsp_valid (rsp_valid),
   .rsp_pa    (rsp_pa),
   .rsp_hit   (rsp_hit),
   .rsp_miss  (rsp_miss),
   .rsp_fault (rsp_fault),
   .rsp_cause (rsp_cause),
   .xlate_en  (xlate_en),
   .fva_q     (fva_q)
);

// File: tb/win_xlate_tb.sv
module win_xlate_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_va = '0;
   logic        req_write = 1'b0;
   logic        req_user = 1'b0;
   logic        rsp_valid;
   logic [31:0] rsp_pa;
   logic [1:0]  rsp_attr;
   logic        rsp_hit, rsp_miss, rsp_fault;
   logic [3:0]  rsp_cause;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   win_xlate u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_va(req_va), .req_write(req_write), .req_user(req_user),
      .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_attr(rsp_attr),
      .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
      end
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic lookup(input logic [31:0] va, input logic wr, input logic usr);
      @(negedge clk);
      req_valid = 1'b1; req_va = va; req_write = wr; req_user = usr;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // expects: pa, attr, {hit,miss,fault}, cause
   task automatic expect_rsp(input string req, input logic [31:0] pa, input logic [1:0] attr,
                             input logic [2:0] flags, input logic [3:0] cause);
      chk(req, "valid", {31'b0, rsp_valid}, 32'd1);
      chk(req, "pa", rsp_pa, pa);
      chk(req, "attr", {30'b0, rsp_attr}, {30'b0, attr});
      chk(req, "flags", {29'b0, rsp_hit, rsp_miss, rsp_fault}, {29'b0, flags});
      chk(req, "cause", {28'b0, rsp_cause}, {28'b0, cause});
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R3", "valid idle", {31'b0, rsp_valid}, 32'd0);
      rd_reg(3'd0, d); chk("R1", "ctrl", d, 32'h0);
      rd_reg(3'd1, d); chk("R1", "fva", d, 32'h0);
      rd_reg(3'd2, d); chk("R1", "fcause", d, 32'h0);
      rd_reg(3'd4, d); chk("R1", "win0", d, 32'h0000_F005);
      rd_reg(3'd5, d); chk("R1", "win1", d, 32'hFDF0_FF0D);
      rd_reg(3'd6, d); chk("R1", "win2", d, 32'hFEF0_FF1D);
   endtask

   task automatic t_bypass();
      logic [31:0] d;
      lookup(32'hFD12_3456, 1'b1, 1'b1);
      expect_rsp("R2", 32'hFD12_3456, 2'b00, 3'b000, 4'h0);
      lookup(32'h0000_0040, 1'b0, 1'b1);
      expect_rsp("R2", 32'h0000_0040, 2'b00, 3'b000, 4'h0);
      rd_reg(3'd2, d); chk("R2", "fcause untouched", d, 32'h0);
      rd_reg(3'd1, d); chk("R2", "fva untouched", d, 32'h0);
   endtask

   task automatic t_default_map();
      logic [31:0] d;
      wr_reg(3'd0, 32'h0000_0003);
      rd_reg(3'd0, d); chk("R11", "ctrl bit1 not writable", d, 32'h1);
      lookup(32'h0123_4567, 1'b0, 1'b0);
      expect_rsp("R4", 32'h0123_4567, 2'b00, 3'b100, 4'h0);
      rd_reg(3'd0, d); chk("R11", "ctrl after hit", d, 32'h3);
      lookup(32'hFD12_3456, 1'b0, 1'b0);
      expect_rsp("R5", 32'hF012_3456, 2'b01, 3'b100, 4'h0);
      lookup(32'hFEAB_CDEF, 1'b1, 1'b0);
      expect_rsp("R6", 32'hF0AB_CDEF, 2'b11, 3'b100, 4'h0);
   endtask

   task automatic t_miss();
      logic [31:0] d;
      lookup(32'h8000_0001, 1'b0, 1'b0);
      expect_rsp("R8", 32'h8000_0001, 2'b00, 3'b010, 4'h0);
      rd_reg(3'd0, d); chk("R11", "ctrl after miss", d, 32'h1);
   endtask

   task automatic t_protection();
      logic [31:0] d;
      lookup(32'h0ABC_0000, 1'b0, 1'b1);
      expect_rsp("R9", 32'h0ABC_0000, 2'b00, 3'b001, 4'h4);
      rd_reg(3'd1, d); chk("R10", "fva user", d, 32'h0ABC_0000);
      rd_reg(3'd2, d); chk("R10", "fcause user", d, 32'h4);
      wr_reg(3'd6, 32'hFEF0_FF1F);
      lookup(32'hFE00_0010, 1'b1, 1'b0);
      expect_rsp("R9", 32'hF000_0010, 2'b11, 3'b001, 4'h2);
      lookup(32'hFE00_0020, 1'b0, 1'b0);
      expect_rsp("R9", 32'hF000_0020, 2'b11, 3'b100, 4'h0);
      rd_reg(3'd1, d); chk("R10", "fva held", d, 32'hFE00_0010);
      rd_reg(3'd2, d); chk("R10", "fcause held", d, 32'h2);
      lookup(32'hFE00_0030, 1'b1, 1'b1);
      expect_rsp("R9", 32'hF000_0030, 2'b11, 3'b001, 4'h6);
      wr_reg(3'd5, 32'hFDF0_FF0C);
      lookup(32'hFD00_0000, 1'b0, 1'b0);
      expect_rsp("R9", 32'hF000_0000, 2'b01, 3'b001, 4'h1);
      wr_reg(3'd1, 32'h0);
      wr_reg(3'd2, 32'h0);
      rd_reg(3'd1, d); chk("R10", "fva cleared", d, 32'h0);
      rd_reg(3'd2, d); chk("R10", "fcause cleared", d, 32'h0);
   endtask

   task automatic t_priority();
      wr_reg(3'd5, 32'h0055_FF09);
      lookup(32'h0000_1234, 1'b0, 1'b0);
      expect_rsp("R7", 32'h0000_1234, 2'b00, 3'b100, 4'h0);
      wr_reg(3'd4, 32'h0000_F004);
      lookup(32'h0000_1234, 1'b0, 1'b0);
      expect_rsp("R7", 32'h0000_1234, 2'b00, 3'b001, 4'h1);
      lookup(32'h0000_5678, 1'b0, 1'b1);
      expect_rsp("R7", 32'h0000_5678, 2'b00, 3'b001, 4'h5);
   endtask

   task automatic t_partial_mask();
      wr_reg(3'd6, 32'h30A0_F009);
      lookup(32'h3712_3456, 1'b1, 1'b1);
      expect_rsp("R5", 32'hA712_3456, 2'b01, 3'b100, 4'h0);
      lookup(32'h3F00_0000, 1'b0, 1'b1);
      expect_rsp("R5", 32'hAF00_0000, 2'b01, 3'b100, 4'h0);
      lookup(32'h4000_0000, 1'b0, 1'b0);
      expect_rsp("R8", 32'h4000_0000, 2'b00, 3'b010, 4'h0);
      @(negedge clk);
      chk("R3", "flags clear idle", {29'b0, rsp_hit, rsp_miss, rsp_fault}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_bypass();
      t_default_map();
      t_miss();
      t_protection();
      t_priority();
      t_partial_mask();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R3 watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule